// File: doc/BRIEF.md
# Vertical Parity Read-Before-Write Updater

This controller sits between a requester and a single-port data array with a one-cycle read latency. It keeps a small bank of vertical parity rows up to date, so that a later recovery pass can rebuild a lost data row. Parity row k holds the bitwise XOR of every data row whose row index, taken modulo the number of parity rows, equals k.

A read request is passed straight to the array, and the data comes back one cycle later. A write request becomes an indivisible pair of array cycles. In the accept cycle the row's old contents are read. In the next cycle the new word is written. The parity row of that group is fetched when the write is accepted and is combined with the old and new words while the write half runs. It is committed one cycle later, so the parity work never adds an array cycle. A fetch of a parity row that still has an uncommitted update takes the pending value.

Top module: `vpar_rbw_ctrl`

## Requirements
- R1: After a synchronous reset, every parity row reads zero on the parity port, rsp_valid is low and req_ready is high.
- R2: An accepted read (req_write=0) drives one array read of req_row in the accept cycle (arr_en=1, arr_we=0). Exactly one cycle later, rsp_valid is high for one cycle and rsp_rdata carries that row's contents.
- R3: An accepted write (req_write=1) drives an array read of req_row in the accept cycle. In the following cycle it drives an array write (arr_en=1, arr_we=1) of req_wdata to the same row, with req_ready low in that cycle.
- R4: Once the block has been idle for two cycles, parity row k (selected by par_sel=k) equals the XOR of all data rows whose index has its low log2(PAR_ROWS) bits equal to k.
- R5: Writes issued back to back to rows of the same parity group lose no update. The parity invariant of R4 still holds after the burst.
- R6: Requests take effect in acceptance order. A read accepted after a write to the same row returns the new word, and a read accepted before it returns the old word.
- R7: The parity update never stalls the request port. req_ready is high in the cycle after every array write cycle.
- R8: Writing a row with the value it already holds leaves every parity row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ADDR_W | Data row index |
| req_wdata | input | DATA_W | Word to write |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| arr_en | output | 1 | Array access enable |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array row index |
| arr_wdata | output | DATA_W | Array write data |
| arr_rdata | input | DATA_W | Array read data, one cycle after a read |
| par_sel | input | log2(PAR_ROWS) | Parity row to observe |
| par_rdata | output | DATA_W | Committed contents of the selected parity row |

## Verification
The two functions that meet in one cycle are the commit of one write's parity update and the parity fetch of the next write in the same group. The bench causes this by issuing writes back to back to rows 32 apart, with no idle cycle between them. It then sweeps every parity row and compares each against a reference XOR of the model's data rows. A lost or doubled update shows up as a mismatch in that group's row. Read-after-write pairs on one row check that the response and the array write come in the right order.

// File: rtl/vpar_pkg.sv
package vpar_pkg;
    localparam int VP_DATA_W   = 32;
    localparam int VP_ADDR_W   = 8;
    localparam int VP_PAR_ROWS = 32;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } seq_state_t;

    function automatic logic [VP_DATA_W-1:0] fold3(
        input logic [VP_DATA_W-1:0] a,
        input logic [VP_DATA_W-1:0] b,
        input logic [VP_DATA_W-1:0] c
    );
        return a ^ b ^ c;
    endfunction
endpackage

// File: rtl/vpar_seq.sv
module vpar_seq
    import vpar_pkg::*;
#(
    parameter int DATA_W = VP_DATA_W,
    parameter int ADDR_W = VP_ADDR_W,
    parameter int PW     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_row,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              arr_en,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              fetch_en,
    output logic [PW-1:0]     fetch_idx,
    output logic              merge_en,
    output logic [DATA_W-1:0] merge_old,
    output logic [DATA_W-1:0] merge_new
);
    typedef struct packed {
        logic [ADDR_W-1:0] row;
        logic [DATA_W-1:0] data;
    } held_op_t;

    seq_state_t state;
    held_op_t   held;
    logic       rd_wait;
    logic       take;

    assign req_ready = (state == ST_IDLE);
    assign take      = req_valid && req_ready;

    always_comb begin
        arr_en    = take || (state == ST_WRITE);
        arr_we    = (state == ST_WRITE);
        arr_addr  = (state == ST_WRITE) ? held.row : req_row;
        arr_wdata = held.data;
    end

    assign fetch_en  = take && req_write;
    assign fetch_idx = req_row[PW-1:0];
    assign merge_en  = (state == ST_WRITE);
    assign merge_old = arr_rdata;
    assign merge_new = held.data;

    assign rsp_valid = rd_wait;
    assign rsp_rdata = arr_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            rd_wait <= 1'b0;
            held    <= '0;
        end else begin
            rd_wait <= take && !req_write;
            case (state)
                ST_IDLE: begin
                    if (take && req_write) begin
                        state     <= ST_WRITE;
                        held.row  <= req_row;
                        held.data <= req_wdata;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vpar_bank.sv
module vpar_bank
    import vpar_pkg::*;
#(
    parameter int DATA_W   = VP_DATA_W,
    parameter int PAR_ROWS = VP_PAR_ROWS,
    localparam int PW      = $clog2(PAR_ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic [PW-1:0]     fetch_idx,
    input  logic              merge_en,
    input  logic [DATA_W-1:0] merge_old,
    input  logic [DATA_W-1:0] merge_new,
    input  logic [PW-1:0]     obs_idx,
    output logic [DATA_W-1:0] obs_data
);
    typedef struct packed {
        logic              valid;
        logic [PW-1:0]     idx;
        logic [DATA_W-1:0] val;
    } pend_t;

    logic [DATA_W-1:0] rows [PAR_ROWS];
    logic [DATA_W-1:0] snap_val;
    logic [PW-1:0]     snap_idx;
    logic [DATA_W-1:0] fwd_val;
    pend_t             pend;

    // A fetch of a row that still has an uncommitted update takes the pending value
    assign fwd_val = (pend.valid && pend.idx == fetch_idx) ? pend.val : rows[fetch_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_val <= '0;
            snap_idx <= '0;
            pend     <= '0;
        end else begin
            if (fetch_en) begin
                snap_val <= fwd_val;
                snap_idx <= fetch_idx;
            end
            pend.valid <= merge_en;
            if (merge_en) begin
                pend.idx <= snap_idx;
                pend.val <= fold3(snap_val, merge_old, merge_new);
            end
        end
    end

    for (genvar k = 0; k < PAR_ROWS; k++) begin : g_row
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (pend.valid && pend.idx == PW'(k)) begin
                q <= pend.val;
            end
        end
        assign rows[k] = q;
    end

    assign obs_data = rows[obs_idx];
endmodule

// File: rtl/vpar_rbw_ctrl.sv
module vpar_rbw_ctrl
    import vpar_pkg::*;
#(
    parameter int DATA_W   = VP_DATA_W,
    parameter int ADDR_W   = VP_ADDR_W,
    parameter int PAR_ROWS = VP_PAR_ROWS,
    localparam int PW      = $clog2(PAR_ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_row,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              arr_en,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [PW-1:0]     par_sel,
    output logic [DATA_W-1:0] par_rdata
);
    logic              fetch_en;
    logic [PW-1:0]     fetch_idx;
    logic              merge_en;
    logic [DATA_W-1:0] merge_old;
    logic [DATA_W-1:0] merge_new;

    vpar_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PW(PW)) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_row(req_row), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
        .fetch_en(fetch_en), .fetch_idx(fetch_idx),
        .merge_en(merge_en), .merge_old(merge_old), .merge_new(merge_new)
    );

    vpar_bank #(.DATA_W(DATA_W), .PAR_ROWS(PAR_ROWS)) u_bank (
        .clk(clk), .rst(rst),
        .fetch_en(fetch_en), .fetch_idx(fetch_idx),
        .merge_en(merge_en), .merge_old(merge_old), .merge_new(merge_new),
        .obs_idx(par_sel), .obs_data(par_rdata)
    );
endmodule

// File: rtl/vpar_rbw_ctrl_chk.sv
module vpar_rbw_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_row,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              arr_en,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [DATA_W-1:0] arr_wdata
);
    // R2
    rd_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |-> (arr_en && !arr_we && arr_addr == req_row));

    // R2
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready && !req_write));

    // R3
    wr_read_half_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |-> (arr_en && !arr_we && arr_addr == req_row));

    // R3
    wr_write_half_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=>
            (arr_en && arr_we && !req_ready && arr_addr == $past(req_row)
             && arr_wdata == $past(req_wdata)));

    // R7
    ready_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_en && arr_we) |=> req_ready);
endmodule

bind vpar_rbw_ctrl vpar_rbw_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .arr_en(arr_en), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata)
);

// File: tb/vpar_rbw_ctrl_bench.sv
`timescale 1ns/1ps
module vpar_rbw_ctrl_bench;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int NR = 256;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_row = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          arr_en, arr_we;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;
    logic [DW-1:0] arr_rdata = '0;
    logic [4:0]    par_sel = '0;
    logic [DW-1:0] par_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] mem     [NR];
    logic [DW-1:0] ref_mem [NR];
    logic [DW-1:0] ref_par [NP];
    logic [DW-1:0] exp_q   [$];

    always #5 clk = ~clk;

    vpar_rbw_ctrl u_vpar_rbw_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
        .par_sel(par_sel), .par_rdata(par_rdata)
    );

    // single-port array with one cycle of read latency
    always @(posedge clk) begin
        if (arr_en) begin
            if (arr_we) mem[arr_addr] <= arr_wdata;
            else        arr_rdata     <= mem[arr_addr];
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle monitor, sampled well after the drive point and before the edge
    logic          prev_rd;
    logic          prev_wr;
    logic [AW-1:0] prev_addr;
    initial begin
        prev_rd = 0; prev_wr = 0; prev_addr = '0;
    end
    always @(negedge clk) begin
        #3;
        if (!rst) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) check("R2 unexpected rsp_valid", 1, 0);
                else check("R2/R6 read data", rsp_rdata, exp_q.pop_front());
            end
            if (arr_en && arr_we) begin
                check("R3 write preceded by read of same row",
                      {31'd0, prev_rd && !prev_wr && prev_addr == arr_addr}, 1);
                check("R3 ready low in write cycle", {31'd0, req_ready}, 0);
            end
            if (prev_wr) check("R7 ready after write cycle", {31'd0, req_ready}, 1);
            prev_rd   = arr_en && !arr_we;
            prev_wr   = arr_en && arr_we;
            prev_addr = arr_addr;
        end
    end

    task automatic send(input logic w, input int row, input logic [DW-1:0] d);
        req_valid = 1; req_write = w; req_row = AW'(row); req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (w) begin
            ref_par[row % NP] ^= ref_mem[row] ^ d;
            ref_mem[row] = d;
        end else begin
            exp_q.push_back(ref_mem[row]);
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic sweep(input string req);
        repeat (3) @(negedge clk);
        for (int k = 0; k < NP; k++) begin
            par_sel = 5'(k);
            #1;
            check(req, par_rdata, ref_par[k]);
        end
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin mem[i] = '0; ref_mem[i] = '0; end
        for (int k = 0; k < NP; k++) ref_par[k] = '0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        #3;
        check("R1 ready after reset", {31'd0, req_ready}, 1);
        check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 0);
        sweep("R1 parity zero after reset");

        // R2 plain reads of zeroed rows
        send(0, 5, 0); send(0, 200, 0);
        // R4 spread writes
        for (int i = 0; i < 40; i++) send(1, (i * 37) % NR, $urandom());
        sweep("R4 parity invariant after spread writes");

        // R5 back-to-back writes in one group (rows 32 apart)
        send(1, 3, 32'hA5A5_0001); send(1, 35, 32'h0F0F_1234);
        send(1, 67, 32'hFFFF_0000); send(1, 99, 32'h1357_9BDF);
        send(1, 3, 32'h2468_ACE0); send(1, 131, 32'hDEAD_BEEF);
        sweep("R5 parity after same-group burst");

        // R6 ordering on one row
        send(0, 77, 0); send(1, 77, 32'hCAFE_F00D); send(0, 77, 0);
        send(1, 77, 32'h0000_1111); send(0, 77, 0);
        sweep("R6 parity after ordered mix");

        // R8 rewrite same value leaves parity unchanged
        send(1, 99, 32'h1357_9BDF);
        sweep("R8 parity unchanged on identical rewrite");

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            if (($urandom() & 3) != 0) send(1, $urandom() % NR, $urandom());
            else                       send(0, $urandom() % NR, 0);
            if (i % 25 == 24) sweep("R4 parity invariant in mixed traffic");
        end
        repeat (3) @(negedge clk);
        check("R2 all responses delivered", exp_q.size(), 0);
        sweep("R4 final parity");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule